// File: doc/BRIEF.md
# Serial Gain Word Loader

This block is the digital control port of a programmable attenuator. Three external lines drive it: a serial data line, a serial clock and an active-low data-enable. It builds an 8-bit gain code from them. The bits enter a shift register with the most significant bit first. A separate gain latch holds the code that is applied to the attenuator core. Data-enable decides which of the two is open. Its falling edge opens a load window, and during the window serial clocks shift bits in while the applied gain stays frozen. Its rising edge closes the window and copies the shifted word into the gain latch.

The external lines have no fixed relation to the system clock, so each one passes through a two-flop synchronizer. Their edges are then found with synchronous logic, which keeps all storage on the one system clock. The shift stage works as master and slave. A rising serial clock samples the data bit into the master. The following falling edge moves that bit into the shift register.

The sleep input and the transmit-enable input pass through the same synchronizers. They come out as registered status lines for the analog core.

Top module: `gain_word_port`

## Requirements
- R1: During reset and after it, until the first commit, gain_o reads 8'h00, gain_valid_o reads 0 and gain_update_o reads 0.
- R2: When 8 serial clocks occur inside one load window, the committed gain equals the 8 data bits taken in the order sent. The first bit sent becomes bit 7 and the last becomes bit 0.
- R3: A low-to-high change on den_n_i copies the shift register into gain_o. It also drives gain_update_o high for exactly one system clock and sets gain_valid_o to 1. gain_valid_o then stays at 1 until reset.
- R4: Serial clocks that occur while den_n_i is high do not change the shift register. If the next window contains no clocks, the commit that follows delivers the word shifted in during the last load window.
- R5: gain_o holds its value during a load window, whatever the serial clock and data lines do. It changes only in the cycle in which gain_update_o is high.
- R6: When more than 8 serial clocks occur in one window, only the last 8 bits shifted in are committed.
- R7: Each bit is the value of the data line at the rising serial clock edge. A change of the data line between that rising edge and the next falling edge has no effect.
- R8: core_awake_o follows sleep_n_i and fwd_tx_en_o follows tx_en_i, each with a delay of two system clocks. Both read 0 during reset.
- R9: A high-to-low change on den_n_i leaves gain_o unchanged and produces no gain_update_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| den_n_i | input | 1 | Data-enable, low opens loading, rising edge commits |
| sleep_n_i | input | 1 | Core power request, 1 = awake |
| tx_en_i | input | 1 | Forward transmission request, 1 = enabled |
| gain_o | output | 8 | Gain code applied to the core |
| gain_valid_o | output | 1 | A commit has occurred since reset |
| gain_update_o | output | 1 | One-cycle pulse when the gain latch is written |
| core_awake_o | output | 1 | Synchronized sleep_n_i |
| fwd_tx_en_o | output | 1 | Synchronized tx_en_i |

## Verification
The shift register cannot be seen at the ports directly. A bit that is lost, shifted out of order or sampled on the wrong serial edge shows up only at the next commit. At that point the gain appears on gain_o about three system clocks after den_n_i rises. A window that fails to freeze shows up as a gain_o change with no gain_update_o pulse, in the same cycle as the fault. The tests therefore commit words after several kinds of window to reveal the hidden state: full windows, over-length windows, windows with no clocks, and windows where the data line changes between clock edges.

// File: rtl/gwp_pkg.sv
// Shared widths and reset values for the serial gain word port.
package gwp_pkg;
    localparam int GAIN_W      = 8;
    localparam int SYNC_STAGES = 2;
    // Order of the synchronized line bundle.
    localparam int LN_SCLK  = 0;
    localparam int LN_SDAT  = 1;
    localparam int LN_DEN   = 2;
    localparam int LN_SLEEP = 3;
    localparam int LN_TXEN  = 4;
    localparam int N_LINES  = 5;
endpackage

// File: rtl/gwp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes each line is a level that is held for several system clocks.
// RST_VAL sets the idle level of each line, so that leaving reset does not look like an edge.
module gwp_sync #(
    parameter int                LINES   = 1,
    parameter int                STAGES  = 2,
    parameter logic [LINES-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    logic [LINES-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Stage g samples the stage before it (or the raw input for stage 0).
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= (g == 0) ? d : stg[(g == 0) ? 0 : g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gwp_edge.sv
// Synchronous edge detector for one synchronized level.
// Assumes the input is already in the clk domain.
// Each output is a single-cycle pulse.
module gwp_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/gwp_shift.sv
// Master-slave serial shift register, MSB first.
// The master samples the data on a serial clock rise.
// The slave shifts the master bit in on the following fall, only while shifting is enabled.
// Assumes rise and fall arrive as single-cycle pulses.
module gwp_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         sdat,
    input  logic         shift_en,
    output logic [W-1:0] word
);
    logic master;

    // Master stage: capture the data bit at the serial rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         master <= 1'b0;
        else if (sclk_rise) master <= sdat;
    end

    // Slave stage: shift toward the MSB at the serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    word <= '0;
        else if (sclk_fall && shift_en) word <= {word[W-2:0], master};
    end
endmodule

// File: rtl/gwp_latch.sv
// Gain latch: holds the applied gain code and writes it only on a commit.
// Raises a one-cycle update pulse and a sticky valid flag when it writes.
module gwp_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] gain,
    output logic         valid,
    output logic         update
);
    // Capture the shifted word on commit and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain   <= '0;
            valid  <= 1'b0;
            update <= 1'b0;
        end else begin
            update <= commit;
            if (commit) begin
                gain  <= word_in;
                valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gain_word_port.sv
// Serial gain word port: three-wire loader for an 8-bit attenuator gain code.
// All external lines are synchronized to clk.
// A data-enable fall opens the load window and a data-enable rise commits the word.
// Assumes each serial level lasts at least three system clocks.
module gain_word_port
    import gwp_pkg::*;
#(
    parameter int W      = GAIN_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk_i,
    input  logic         ser_dat_i,
    input  logic         den_n_i,
    input  logic         sleep_n_i,
    input  logic         tx_en_i,
    output logic [W-1:0] gain_o,
    output logic         gain_valid_o,
    output logic         gain_update_o,
    output logic         core_awake_o,
    output logic         fwd_tx_en_o
);
    localparam logic [N_LINES-1:0] IDLE = N_LINES'(1) << LN_DEN;

    logic [N_LINES-1:0] raw, syn;
    logic sclk_rise, sclk_fall;
    logic den_rise, den_fall;
    logic load_win;
    logic [W-1:0] sh_word;

    assign raw[LN_SCLK]  = ser_clk_i;
    assign raw[LN_SDAT]  = ser_dat_i;
    assign raw[LN_DEN]   = den_n_i;
    assign raw[LN_SLEEP] = sleep_n_i;
    assign raw[LN_TXEN]  = tx_en_i;

    gwp_sync #(.LINES(N_LINES), .STAGES(STAGES), .RST_VAL(IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    gwp_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[LN_SCLK]), .rise(sclk_rise), .fall(sclk_fall)
    );

    gwp_edge #(.RST_VAL(1'b1)) u_den_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[LN_DEN]), .rise(den_rise), .fall(den_fall)
    );

    // Load window: opened by a data-enable fall, closed by a rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        load_win <= 1'b0;
        else if (den_fall) load_win <= 1'b1;
        else if (den_rise) load_win <= 1'b0;
    end

    gwp_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdat(syn[LN_SDAT]), .shift_en(load_win), .word(sh_word)
    );

    gwp_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n), .commit(den_rise), .word_in(sh_word),
        .gain(gain_o), .valid(gain_valid_o), .update(gain_update_o)
    );

    assign core_awake_o = syn[LN_SLEEP];
    assign fwd_tx_en_o  = syn[LN_TXEN];
endmodule

// File: rtl/gain_word_port_chk.sv
// Property checker for gain_word_port, attached with bind.
module gain_word_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] gain_o,
    input logic         gain_valid_o,
    input logic         gain_update_o,
    input logic         den_rise,
    input logic         load_win,
    input logic [W-1:0] sh_word
);
    // R5
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_update_o |-> $stable(gain_o));
    // R3
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        den_rise |=> gain_update_o);
    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_update_o |=> !gain_update_o);
    // R3
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_valid_o |=> gain_valid_o);
    // R1
    valid_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_valid_o) |-> gain_update_o);
    // R4
    shift_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_win |=> $stable(sh_word));
endmodule

bind gain_word_port gain_word_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gain_o(gain_o), .gain_valid_o(gain_valid_o),
    .gain_update_o(gain_update_o), .den_rise(den_rise), .load_win(load_win),
    .sh_word(sh_word)
);

// File: tb/gain_word_port_test.sv
// Scoreboard bench: commit tasks queue the expected gain, and a monitor checks every update pulse.
module gain_word_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, den_n = 1'b1, slp = 1'b0, txe = 1'b0;
    logic [7:0] gain;
    logic valid, upd, awake, fwd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] expq [$];
    logic [7:0] last_gain = 8'h00;

    always #4 clk = ~clk;

    gain_word_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .den_n_i(den_n),
        .sleep_n_i(slp), .tx_en_i(txe), .gain_o(gain), .gain_valid_o(valid),
        .gain_update_o(upd), .core_awake_o(awake), .fwd_tx_en_o(fwd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; the data line may flip between the clock rise and fall (R7).
    task automatic send_bit(input logic b, input logic after_rise);
        sdat = b;        wait_n(6);
        sclk = 1'b1;     wait_n(6);
        sdat = after_rise; wait_n(6);
        sclk = 1'b0;     wait_n(6);
    endtask

    task automatic send_word(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) send_bit(w[i], w[i]);
    endtask

    task automatic open_win();
        den_n = 1'b0; wait_n(8);
    endtask

    task automatic commit(input logic [7:0] exp);
        expq.push_back(exp);
        den_n = 1'b1; wait_n(10);
        last_gain = exp;
    endtask

    // Monitor: pop and compare on every update pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && upd) begin
                if (expq.size() == 0) begin
                    check("R9 unexpected update", 8'h01, 8'h00);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check("R2/R3 committed gain", gain, e);
                    check("R3 valid on commit", {7'b0, valid}, 8'h01);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        // R1 during reset
        check("R1 gain in reset", gain, 8'h00);
        check("R1 valid in reset", {7'b0, valid}, 8'h00);
        check("R1 update in reset", {7'b0, upd}, 8'h00);
        check("R8 awake in reset", {7'b0, awake}, 8'h00);
        rst_n = 1'b1; wait_n(6);
        check("R1 gain after reset", gain, 8'h00);
        check("R1 valid after reset", {7'b0, valid}, 8'h00);

        // R2 basic word, R5 gain held mid window
        open_win();
        send_word(8'hA5);
        check("R5 gain held while loading", gain, 8'h00);
        commit(8'hA5);
        check("R3 gain after commit", gain, 8'hA5);

        // R9 falling edge holds gain
        open_win();
        check("R9 gain after den fall", gain, 8'hA5);
        send_word(8'h3C);
        check("R5 gain held while loading 2", gain, 8'hA5);
        commit(8'h3C);

        // R4 clocks while den high are ignored
        send_word(8'hF0);
        open_win();
        commit(8'h3C);
        check("R4 gain after idle clocks", gain, 8'h3C);

        // R6 over-length window keeps last 8
        open_win();
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b1);
        send_word(8'h69);
        commit(8'h69);
        check("R6 last eight bits", gain, 8'h69);

        // R7 data flips after rise: captured value is the one at the rise
        open_win();
        for (int i = 7; i >= 0; i--) send_bit(8'hC3 >> i, ~(8'hC3 >> i));
        commit(8'hC3);
        check("R7 sampled at rising edge", gain, 8'hC3);

        // R8 pass-through of sleep and transmit enable
        slp = 1'b1; txe = 1'b0; wait_n(1);
        check("R8 awake before latency", {7'b0, awake}, 8'h00);
        wait_n(3);
        check("R8 awake high", {7'b0, awake}, 8'h01);
        check("R8 fwd low", {7'b0, fwd}, 8'h00);
        slp = 1'b0; txe = 1'b1; wait_n(4);
        check("R8 awake low", {7'b0, awake}, 8'h00);
        check("R8 fwd high", {7'b0, fwd}, 8'h01);

        wait_n(10);
        check("R3 scoreboard drained", 8'(expq.size()), 8'h00);
        check("R5 final gain", gain, last_gain);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule